// File: doc/BRIEF.md
# Packed-Lane Absolute-Sum Vector Unit

This unit executes one family of 128-bit SIMD instructions. For every lane, it adds the magnitude of one source lane to the magnitude of the matching lane in the other source. It receives a 32-bit instruction word together with two 128-bit operand vectors, which have already been read from the register file. The unit decodes the word. If the word belongs to the family, the unit returns the destination register index and the packed result one clock later.

A two-bit size code in the instruction selects the lane width at run time: 8, 16, 32 or 64 bits. Each lane treats its contents as a two's-complement value. Each lane wraps modulo its own width, and no carry ever crosses a lane boundary. There is no back-pressure. An accepted input produces exactly one output pulse on the next cycle.

Top module: `vec_absadd`

## Requirements
- R1: Each result lane equals |a| + |b| of the corresponding source lanes, where a negative lane value is negated and a non-negative value passes unchanged.
- R2: Instruction bits 16:15 select the lane width: 00 gives 16 lanes of 8 bits, 01 gives 8 lanes of 16 bits, 10 gives 4 lanes of 32 bits, and 11 gives 2 lanes of 64 bits. Lane i occupies bits [i*W +: W].
- R3: Lanes are independent. A lane sum that exceeds the lane width never changes any neighbouring lane.
- R4: Each lane sum is truncated to the lane width, with no saturation.
- R5: The most negative lane value keeps its bit pattern under the magnitude step (for example 0x80 for bytes), and the sum then wraps normally.
- R6: `match_o` is high, combinationally, exactly when instruction bits 31:17 equal binary 011100000101110.
- R7: An input with `valid_i` high and a non-matching instruction does not raise `valid_o`, and it leaves `result_o` and `dest_o` unchanged.
- R8: `dest_o` carries instruction bits 4:0 of the accepted instruction. Bits 9:5 and 14:10 name the sources and do not affect the datapath.
- R9: `valid_o`, `result_o` and `dest_o` update on the first clock edge after an accepted input. `valid_o` falls on the next edge unless a new operation is accepted.
- R10: Asserting `rst_ni` low clears `valid_o`, `result_o` and `dest_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operands present |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| match_o | output | 1 | Instruction belongs to the absolute-sum family |
| valid_o | output | 1 | Registered result is valid |
| dest_o | output | 5 | Destination register index |
| result_o | output | 128 | Packed lane results |

## Verification
The hardest cases to reach are the lane-boundary wraps: the most negative value in every lane, and maximum-positive pairs whose sum overflows into what would be a neighbour's bits. Random operands almost never produce these. Directed tasks therefore build vectors by replicating the lane-width minimum, maximum, zero and all-ones patterns across the whole register, and apply each pattern at all four size codes. The results are compared against a bench model that extracts each lane by shifting. Miss-then-hold sequences confirm that a rejected word leaves the previous result in place.

// File: rtl/vec_absadd_pkg.sv
package vec_absadd_pkg;
  localparam int VLEN    = 128;
  localparam int ILEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int NUM_SZ  = 4;
  localparam int OPC_LSB = 17;
  localparam int OPC_W   = ILEN - OPC_LSB;
  localparam logic [OPC_W-1:0] OPC_ABSADD = 15'b011100000101110;
  localparam int SZ_LSB  = 15;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_H16 = 2'd1,
    SZ_W32 = 2'd2,
    SZ_D64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/vec_absadd_dec.sv
module vec_absadd_dec
  import vec_absadd_pkg::*;
(
  input  logic [ILEN-1:0]   instr_i,
  output logic              match_o,
  output lane_sz_e          size_o,
  output logic [NUM_SZ-1:0] sel_o,
  output logic [RIDX_W-1:0] dest_o
);
  assign match_o = (instr_i[ILEN-1:OPC_LSB] == OPC_ABSADD);
  assign size_o  = lane_sz_e'(instr_i[SZ_LSB+1:SZ_LSB]);
  assign dest_o  = instr_i[RIDX_W-1:0];

  always_comb begin
    sel_o = '0;
    if (match_o) sel_o[size_o] = 1'b1;
  end

  always_comb begin
    AST_SEL_ONEHOT0: assert ($onehot0(sel_o)); // R2
    if (match_o) begin
      AST_SEL_ONE_ON_MATCH: assert ($countones(sel_o) == 1); // R6
    end
  end
endmodule

// File: rtl/vec_absadd_lane.sv
module vec_absadd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] mag_a, mag_b;

  // negation of the minimum value wraps to itself
  assign mag_a = a_i[W-1] ? (~a_i + W'(1)) : a_i;
  assign mag_b = b_i[W-1] ? (~b_i + W'(1)) : b_i;
  assign sum_o = mag_a + mag_b;

  always_comb begin
    if (a_i == '0 && b_i == '0) begin
      AST_ZERO_IN_ZERO_OUT: assert (sum_o == '0); // R1
    end
  end
endmodule

// File: rtl/vec_absadd_slice.sv
module vec_absadd_slice #(
  parameter int W    = 8,
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] a_i,
  input  logic [VLEN-1:0] b_i,
  output logic [VLEN-1:0] res_o
);
  localparam int NLANE = VLEN / W;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    vec_absadd_lane #(.W(W)) u_lane (
      .a_i  (a_i[l*W +: W]),
      .b_i  (b_i[l*W +: W]),
      .sum_o(res_o[l*W +: W])
    );
  end
endmodule

// File: rtl/vec_absadd.sv
module vec_absadd
  import vec_absadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [127:0]      src_a_i,
  input  logic [127:0]      src_b_i,
  output logic              match_o,
  output logic              valid_o,
  output logic [4:0]        dest_o,
  output logic [127:0]      result_o
);
  lane_sz_e          size;
  logic [NUM_SZ-1:0] sel;
  logic [RIDX_W-1:0] dest_d;
  logic [VLEN-1:0]   res_by_sz [NUM_SZ];
  logic [VLEN-1:0]   res_d;
  logic              accept;

  vec_absadd_dec u_dec (
    .instr_i(instr_i),
    .match_o(match_o),
    .size_o (size),
    .sel_o  (sel),
    .dest_o (dest_d)
  );

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_width
    localparam int W = 8 << g;
    vec_absadd_slice #(.W(W), .VLEN(VLEN)) u_slice (
      .a_i  (src_a_i),
      .b_i  (src_b_i),
      .res_o(res_by_sz[g])
    );
  end

  always_comb begin
    res_d = '0;
    for (int s = 0; s < NUM_SZ; s++) begin
      if (sel[s]) res_d = res_by_sz[s];
    end
  end

  assign accept = valid_i & match_o;

  logic              valid_q;
  logic [RIDX_W-1:0] dest_q;
  logic [VLEN-1:0]   result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      dest_q   <= '0;
      result_q <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        dest_q   <= dest_d;
        result_q <= res_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign dest_o   = dest_q;
  assign result_o = result_q;

  AST_VALID_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && match_o)); // R9
  AST_MISS_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !match_o) |=> !valid_o); // R7
  AST_MISS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && match_o) |=> ($stable(result_o) && $stable(dest_o))); // R7
  AST_DEST_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && match_o) |=> (dest_o == $past(instr_i[4:0]))); // R8
  AST_ZERO_OPERANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && match_o && src_a_i == '0 && src_b_i == '0) |=> (result_o == '0)); // R1
endmodule

// File: tb/vec_absadd_bench.sv
module vec_absadd_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [14:0] OPC = 15'b011100000101110;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b;
  logic         match, valid_o;
  logic [4:0]   dest;
  logic [127:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_absadd u_vec_absadd (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr),
    .src_a_i(src_a), .src_b_i(src_b), .match_o(match), .valid_o(valid_o),
    .dest_o(dest), .result_o(result)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz);
    int w = 8 << sz;
    logic [127:0] mask = (128'd1 << w) - 128'd1;
    logic [127:0] r = '0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [127:0] la = (a >> (i * w)) & mask;
      logic [127:0] lb = (b >> (i * w)) & mask;
      if (la[w-1]) la = (~la + 128'd1) & mask;
      if (lb[w-1]) lb = (~lb + 128'd1) & mask;
      r |= ((la + lb) & mask) << (i * w);
    end
    return r;
  endfunction

  function automatic logic [127:0] splat(input logic [63:0] v, input logic [1:0] sz);
    int w = 8 << sz;
    logic [127:0] r = '0;
    for (int i = 0; i < 128 / w; i++) r |= (128'(v) & ((128'd1 << w) - 128'd1)) << (i * w);
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [31:0] mk_instr(input logic [1:0] sz, input logic [4:0] rd,
                                           input logic [4:0] rj, input logic [4:0] rk);
    return {OPC, sz, rk, rj, rd};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next posedge
  task automatic issue(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    valid_i = 1'b1; instr = ins; src_a = a; src_b = b;
    @(posedge clk); #1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [1:0] sz,
                        input logic [127:0] a, input logic [127:0] b);
    logic [4:0] rd = 5'($urandom());
    @(negedge clk);
    valid_i = 1'b1; instr = mk_instr(sz, rd, 5'($urandom()), 5'($urandom()));
    src_a = a; src_b = b;
    @(posedge clk); #1;
    chk({req, " valid"}, 128'(valid_o), 128'd1);
    chk(req, result, model(a, b, sz));
    chk({req, " dest"}, 128'(dest), 128'(rd));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; valid_i = 1'b0; instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid", 128'(valid_o), 128'd0);
    chk("R10 result", result, 128'd0);
    chk("R10 dest", 128'(dest), 128'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_decode();
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      instr = mk_instr(2'(s), 5'd1, 5'd2, 5'd3); #1;
      chk("R6 match", 128'(match), 128'd1);
    end
    instr = {OPC ^ 15'h0001, 17'h0}; #1;
    chk("R6 near miss low bit", 128'(match), 128'd0);
    instr = {OPC ^ 15'h4000, 17'h0}; #1;
    chk("R6 near miss top bit", 128'(match), 128'd0);
  endtask

  task automatic t_literals();
    // bytes: -3 and 5 -> 8 in every lane
    run_op("R1 literal", 2'd0, splat(64'hFD, 2'd0), splat(64'h05, 2'd0));
    chk("R1 literal value", result, {16{8'h08}});
    run_op("R5 min byte", 2'd0, {16{8'h80}}, '0);
    chk("R5 min byte value", result, {16{8'h80}});
    run_op("R4 max word wrap", 2'd2, {4{32'h7FFFFFFF}}, {4{32'h00000001}});
    chk("R4 max word wrap value", result, {4{32'h80000000}});
    run_op("R3 byte carry", 2'd0, {16{8'h7F}}, {16{8'h7F}});
    chk("R3 byte carry value", result, {16{8'hFE}});
    run_op("R2 dword lanes", 2'd3, {64'hFFFFFFFFFFFFFFFF, 64'h0000000000000003},
           {64'h0000000000000002, 64'hFFFFFFFFFFFFFFFC});
    chk("R2 dword lanes value", result, {64'd3, 64'd7});
  endtask

  task automatic t_corners();
    logic [63:0] pats [5] = '{64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000,
                              64'h7FFFFFFFFFFFFFFF, 64'h0000000000000001};
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          logic [63:0] pi = pats[i];
          logic [63:0] pj = pats[j];
          if (i == 2) pi = 64'd1 << (w - 1);
          if (j == 2) pj = 64'd1 << (w - 1);
          if (i == 3) pi = (64'd1 << (w - 1)) - 64'd1;
          if (j == 3) pj = (64'd1 << (w - 1)) - 64'd1;
          if (w == 64 && i == 3) pi = 64'h7FFFFFFFFFFFFFFF;
          if (w == 64 && j == 3) pj = 64'h7FFFFFFFFFFFFFFF;
          run_op("R5 R3 corner", 2'(s), splat(pi, 2'(s)), splat(pj, 2'(s)));
        end
      end
    end
  endtask

  task automatic t_random();
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 40; k++)
        run_op("R1 R2 random", 2'(s), rnd128(), rnd128());
  endtask

  task automatic t_miss_hold();
    logic [127:0] held_r;
    logic [4:0]   held_d;
    run_op("R9 before miss", 2'd1, rnd128(), rnd128());
    held_r = result; held_d = dest;
    issue({OPC ^ 15'h0100, 17'h1ABCD}, rnd128(), rnd128());
    chk("R7 no valid", 128'(valid_o), 128'd0);
    chk("R7 result held", result, held_r);
    chk("R7 dest held", 128'(dest), 128'(held_d));
    // R8: source fields do not steer data
    run_op("R8 src fields", 2'd2, {4{32'hFFFFFFF0}}, {4{32'h00000010}});
    chk("R8 src fields value", result, {4{32'h00000020}});
  endtask

  task automatic t_latency();
    run_op("R9 pulse", 2'd0, rnd128(), rnd128());
    @(posedge clk); #1;
    chk("R9 valid falls", 128'(valid_o), 128'd0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    t_reset();
    t_decode();
    t_literals();
    t_corners();
    t_random();
    t_miss_hold();
    t_latency();
    finished = 1'b1;
    report();
  end
endmodule